// File: doc/BRIEF.md
# Phase-Lock Qualification Detector

This block judges whether a phase-locked loop is in lock by looking at the phase error once per comparison cycle. The raw phase-detector error signal comes in as a level. While that level is high, the block counts fast-clock cycles. At every comparison strobe from the loop's feedback divider, it latches the accumulated count as the error width for that cycle and compares it with a programmable threshold. A width strictly below the threshold is a good cycle. A width at or above it is a bad cycle. A strobe that fails to arrive within a programmable number of clocks also counts as a bad cycle, so a stopped reference clears lock.

The good and bad verdicts drive a qualification state machine with asymmetric behaviour. Lock is declared only after a run of consecutive good cycles, eight by default. A single bad cycle drops lock at once and empties the run. The state machine has three states:

- `ST_UNLOCKED`: the run is empty.
- `ST_QUALIFY`: the run is partly built.
- `ST_LOCKED`: lock is declared.

Its transitions are:

- `good`: `ST_UNLOCKED`→`ST_QUALIFY`, `ST_QUALIFY`→`ST_QUALIFY`, or into `ST_LOCKED` when the run reaches the target.
- `stay`: `ST_LOCKED`→`ST_LOCKED` on a good verdict.
- `drop`: any state→`ST_UNLOCKED` on a bad verdict or a timeout.

A separate drive-enable input is registered to produce the enable that a pad would use to float the lock pin. A synchronous reset clears everything.

Top module: `phase_lock_qualifier`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears `locked_o`, `locked_oe_o` and the good-cycle run. After reset, `locked_o` stays low until a full run of good cycles is seen.
- R2: The error width of a comparison cycle is the number of clock cycles with `err_i` high. The count runs from the cycle after the previous strobe through the strobe cycle itself. It saturates at 2^WIDTH_W-1 (255 by default) and does not wrap.
- R3: A cycle is good when its width is strictly less than `thresh_i`, sampled in the strobe cycle. A width equal to the threshold is bad.
- R4: `locked_o` rises on the second clock edge after the strobe cycle that completes QUAL_COUNT (8) consecutive good cycles. It does not rise after QUAL_COUNT-1 of them.
- R5: One bad cycle drops `locked_o` on the second clock edge after its strobe cycle and empties the run.
- R6: The run saturates at QUAL_COUNT. Further good cycles keep the block locked. After a drop, a full new run of QUAL_COUNT good cycles is needed again.
- R7: With `timeout_i` nonzero, `timeout_i` consecutive clock cycles without a strobe count as one bad cycle. `locked_o` falls on the second edge after the last of those cycles, and the timeout count restarts. A `timeout_i` of 0 disables the timeout.
- R8: `locked_oe_o` equals `drive_en_i` delayed by one clock. `drive_en_i` has no effect on `locked_o`.
- R9: `locked_o` changes only on the edge that follows a registered verdict or timeout event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast measurement clock |
| rst | input | 1 | Synchronous reset, active high |
| err_i | input | 1 | Phase-detector error level, high while an error is present |
| strobe_i | input | 1 | One-cycle comparison strobe from the feedback divider |
| thresh_i | input | WIDTH_W | Error-width threshold in clock cycles |
| timeout_i | input | TIMEOUT_W | Clock cycles without a strobe before a bad cycle is forced; 0 disables |
| drive_en_i | input | 1 | Drive enable for the lock pin |
| locked_o | output | 1 | Registered lock flag |
| locked_oe_o | output | 1 | Registered enable for the lock pin; low means the pin is floated |

## Verification
The hardest conditions to reach from the ports are the width boundaries: a width exactly equal to the threshold, and a width pushed past the saturation point. In the second case, a wrapping counter would read as a small, good width. The bench first builds a full lock, then sets the threshold to the counter's maximum. It then runs one comparison cycle with 254 error cycles, which must keep lock, and one with 300, which must drop it. The timeout is disabled during these long cycles so that the watchdog cannot mask the result. The stopped-reference case is reached by withholding strobes around the programmed timeout: lock must still be held just short of it and cleared just past it.

// File: rtl/plq_pkg.sv
package plq_pkg;

    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'd0,
        ST_QUALIFY  = 2'd1,
        ST_LOCKED   = 2'd2
    } qual_state_e;

    typedef struct packed {
        logic vld;
        logic good;
    } verdict_t;

endpackage

// File: rtl/pl_err_meter.sv
// Measures the error pulse width per comparison cycle and grades it.
module pl_err_meter #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               err_i,
    input  logic               strobe_i,
    input  logic [WIDTH_W-1:0] thresh_i,
    output plq_pkg::verdict_t  verdict_o,
    output logic [WIDTH_W-1:0] width_o
);
    localparam logic [WIDTH_W-1:0] WIDTH_MAX = {WIDTH_W{1'b1}};

    logic [WIDTH_W-1:0] acc_q;
    logic [WIDTH_W:0]   acc_ext;
    logic [WIDTH_W-1:0] acc_sat;

    always_comb begin
        acc_ext = {1'b0, acc_q} + {{WIDTH_W{1'b0}}, err_i};
        acc_sat = acc_ext[WIDTH_W] ? WIDTH_MAX : acc_ext[WIDTH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            width_o   <= '0;
            verdict_o <= '0;
        end else if (strobe_i) begin
            acc_q          <= '0;
            width_o        <= acc_sat;
            verdict_o.vld  <= 1'b1;
            verdict_o.good <= (acc_sat < thresh_i);
        end else begin
            acc_q          <= acc_sat;
            verdict_o.vld  <= 1'b0;
            verdict_o.good <= 1'b0;
        end
    end

endmodule

// File: rtl/pl_strobe_watchdog.sv
// Flags a missing comparison strobe after a programmable number of cycles.
module pl_strobe_watchdog #(
    parameter int TIMEOUT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe_i,
    input  logic [TIMEOUT_W-1:0] timeout_i,
    output logic                 miss_o
);
    localparam logic [TIMEOUT_W-1:0] IDLE_MAX = {TIMEOUT_W{1'b1}};

    logic [TIMEOUT_W-1:0] idle_q;
    logic [TIMEOUT_W:0]   idle_inc;
    logic                 expire;

    always_comb begin
        idle_inc = {1'b0, idle_q} + 1'b1;
        expire   = (timeout_i != '0) && (idle_inc == {1'b0, timeout_i});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
            miss_o <= 1'b0;
        end else begin
            miss_o <= 1'b0;
            if (strobe_i) begin
                idle_q <= '0;
            end else if (expire) begin
                idle_q <= '0;
                miss_o <= 1'b1;
            end else if (idle_q != IDLE_MAX) begin
                idle_q <= idle_inc[TIMEOUT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pl_qual_fsm.sv
// Asymmetric lock qualification: a full run of good cycles to lock, one bad to drop.
module pl_qual_fsm #(
    parameter int QUAL_COUNT = 8,
    localparam int RUN_W     = $clog2(QUAL_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             good_ev,
    input  logic             bad_ev,
    output logic             locked_o,
    output logic [RUN_W-1:0] run_o
);
    import plq_pkg::*;

    localparam logic [RUN_W-1:0] RUN_TARGET = RUN_W'(QUAL_COUNT);

    qual_state_e      state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic [RUN_W-1:0] run_inc;

    assign run_inc = run_q + 1'b1;

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (bad_ev) begin
            state_d = ST_UNLOCKED;
            run_d   = '0;
        end else if (good_ev) begin
            unique case (state_q)
                ST_UNLOCKED, ST_QUALIFY: begin
                    run_d   = run_inc;
                    state_d = (run_inc == RUN_TARGET) ? ST_LOCKED : ST_QUALIFY;
                end
                ST_LOCKED: begin
                    state_d = ST_LOCKED;
                    run_d   = RUN_TARGET;
                end
                default: begin
                    state_d = ST_UNLOCKED;
                    run_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_UNLOCKED;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            locked_o <= 1'b0;
        end else begin
            locked_o <= (state_d == ST_LOCKED);
        end
    end

    assign run_o = run_q;

endmodule

// File: rtl/phase_lock_qualifier.sv
module phase_lock_qualifier #(
    parameter int WIDTH_W    = 8,
    parameter int TIMEOUT_W  = 16,
    parameter int QUAL_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 err_i,
    input  logic                 strobe_i,
    input  logic [WIDTH_W-1:0]   thresh_i,
    input  logic [TIMEOUT_W-1:0] timeout_i,
    input  logic                 drive_en_i,
    output logic                 locked_o,
    output logic                 locked_oe_o
);
    import plq_pkg::*;

    localparam int RUN_W = $clog2(QUAL_COUNT + 1);

    verdict_t           verdict;
    logic [WIDTH_W-1:0] meas_width;
    logic               strobe_miss;
    logic               good_ev;
    logic               bad_ev;
    logic [RUN_W-1:0]   run_cnt;

    pl_err_meter #(.WIDTH_W(WIDTH_W)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .err_i     (err_i),
        .strobe_i  (strobe_i),
        .thresh_i  (thresh_i),
        .verdict_o (verdict),
        .width_o   (meas_width)
    );

    pl_strobe_watchdog #(.TIMEOUT_W(TIMEOUT_W)) u_watchdog (
        .clk       (clk),
        .rst       (rst),
        .strobe_i  (strobe_i),
        .timeout_i (timeout_i),
        .miss_o    (strobe_miss)
    );

    assign good_ev = verdict.vld & verdict.good;
    assign bad_ev  = strobe_miss | (verdict.vld & ~verdict.good);

    pl_qual_fsm #(.QUAL_COUNT(QUAL_COUNT)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .good_ev  (good_ev),
        .bad_ev   (bad_ev),
        .locked_o (locked_o),
        .run_o    (run_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_oe_o <= 1'b0;
        end else begin
            locked_oe_o <= drive_en_i;
        end
    end

endmodule

// File: rtl/phase_lock_qualifier_chk.sv
module phase_lock_qualifier_chk #(
    parameter int WIDTH_W    = 8,
    parameter int QUAL_COUNT = 8,
    localparam int RUN_W     = $clog2(QUAL_COUNT + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               strobe_i,
    input logic [WIDTH_W-1:0] thresh_i,
    input logic               drive_en_i,
    input logic               locked_o,
    input logic               locked_oe_o,
    input logic               ev_vld,
    input logic               ev_good,
    input logic [WIDTH_W-1:0] ev_width,
    input logic               ev_miss,
    input logic [RUN_W-1:0]   run_cnt
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!locked_o && !locked_oe_o));                        // R1

    AST_WIDTH_GRADE: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ev_vld) |-> (ev_good == (ev_width < $past(thresh_i)))); // R3

    AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> (run_cnt == RUN_W'(QUAL_COUNT)));                // R4

    AST_BAD_DROPS: assert property (@(posedge clk) disable iff (rst)
        ((ev_vld && !ev_good) || ev_miss) |=> (!locked_o && run_cnt == '0)); // R5

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= RUN_W'(QUAL_COUNT));                                      // R6

    AST_TIMEOUT_DROPS: assert property (@(posedge clk) disable iff (rst)
        ev_miss |=> !locked_o);                                              // R7

    AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (locked_oe_o == $past(drive_en_i)));                 // R8

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ev_vld && !ev_miss) |=> $stable(locked_o));                        // R9

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
        ev_miss |-> !$past(strobe_i));                                       // R7

endmodule

bind phase_lock_qualifier phase_lock_qualifier_chk #(
    .WIDTH_W    (WIDTH_W),
    .QUAL_COUNT (QUAL_COUNT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .strobe_i    (strobe_i),
    .thresh_i    (thresh_i),
    .drive_en_i  (drive_en_i),
    .locked_o    (locked_o),
    .locked_oe_o (locked_oe_o),
    .ev_vld      (verdict.vld),
    .ev_good     (verdict.good),
    .ev_width    (meas_width),
    .ev_miss     (strobe_miss),
    .run_cnt     (run_cnt)
);

// File: tb/phase_lock_qualifier_bench.sv
`timescale 1ns/1ps
module phase_lock_qualifier_bench;

    localparam int QUAL  = 8;
    localparam int W_MAX = 255;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_i = 1'b0;
    logic        strobe_i = 1'b0;
    logic [7:0]  thresh_i = 8'd5;
    logic [15:0] timeout_i = 16'd200;
    logic        drive_en_i = 1'b0;
    logic        locked_o;
    logic        locked_oe_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int m_acc = 0, m_idle = 0, m_run = 0;
    bit m_lock = 0, m_oe = 0, m_good_p = 0, m_bad_p = 0;

    always #2 clk = ~clk;

    phase_lock_qualifier u_phase_lock_qualifier (
        .clk(clk), .rst(rst), .err_i(err_i), .strobe_i(strobe_i),
        .thresh_i(thresh_i), .timeout_i(timeout_i), .drive_en_i(drive_en_i),
        .locked_o(locked_o), .locked_oe_o(locked_oe_o)
    );

    always @(posedge clk) begin
        int w;
        bit miss;
        if (rst) begin
            m_acc = 0; m_idle = 0; m_run = 0;
            m_lock = 0; m_oe = 0; m_good_p = 0; m_bad_p = 0;
        end else begin
            if (m_bad_p) begin
                m_run = 0; m_lock = 0;
            end else if (m_good_p) begin
                if (m_run < QUAL) m_run++;
                m_lock = (m_run >= QUAL);
            end
            m_oe = drive_en_i;
            m_good_p = 0; m_bad_p = 0;
            w = m_acc + (err_i ? 1 : 0);
            if (w > W_MAX) w = W_MAX;
            if (strobe_i) begin
                m_good_p = (w < thresh_i);
                m_bad_p  = !(w < thresh_i);
                m_acc = 0;
            end else begin
                m_acc = w;
            end
            miss = 0;
            if (strobe_i) m_idle = 0;
            else if (timeout_i != 0 && m_idle + 1 == timeout_i) begin
                miss = 1; m_idle = 0;
            end else if (m_idle < 65535) m_idle++;
            if (miss) m_bad_p = 1;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk("R9 locked_o vs model", locked_o, m_lock);
            chk("R8 locked_oe_o vs model", locked_oe_o, m_oe);
        end
    end

    // one comparison cycle: n non-strobe cycles, err high for the first e, then the strobe
    task automatic phase(input int n, input int e);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            strobe_i = 1'b0;
            err_i = (i < e);
        end
        @(negedge clk);
        strobe_i = 1'b1;
        err_i = 1'b0;
        @(negedge clk);
        strobe_i = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset locked_o", locked_o, 1'b0);
        chk("R1 reset locked_oe_o", locked_oe_o, 1'b0);
        rst = 1'b0;
        drive_en_i = 1'b1;

        // R4: seven good cycles are not enough, the eighth locks
        for (int k = 0; k < 7; k++) phase(10, 3);
        settle();
        chk("R4 no lock after 7", locked_o, 1'b0);
        phase(10, 2);
        settle();
        chk("R4 lock after 8", locked_o, 1'b1);

        // R6: run saturates, lock holds
        for (int k = 0; k < 20; k++) phase(10, 4);
        settle();
        chk("R6 lock holds", locked_o, 1'b1);

        // R3/R5: width equal to threshold is bad and drops lock
        phase(10, 5);
        settle();
        chk("R3 equal width is bad", locked_o, 1'b0);

        // R6: full new run needed
        for (int k = 0; k < 7; k++) phase(10, 4);
        settle();
        chk("R6 no relock after 7", locked_o, 1'b0);
        phase(10, 0);
        settle();
        chk("R6 relock after 8", locked_o, 1'b1);

        // R5: a single wide error drops lock
        phase(10, 9);
        settle();
        chk("R5 single bad drops", locked_o, 1'b0);

        // R2: long cycles, exact count and saturation (timeout disabled, R7)
        timeout_i = 16'd0;
        thresh_i = 8'd255;
        for (int k = 0; k < 8; k++) phase(10, 4);
        settle();
        chk("R2 locked before long cycles", locked_o, 1'b1);
        phase(260, 254);
        settle();
        chk("R2 width 254 below 255 good, R7 disabled", locked_o, 1'b1);
        phase(300, 300);
        settle();
        chk("R2 saturated width bad", locked_o, 1'b0);

        // R7: stopped strobe forces a bad cycle
        thresh_i = 8'd5;
        timeout_i = 16'd40;
        for (int k = 0; k < 8; k++) phase(10, 0);
        settle();
        chk("R7 locked before stop", locked_o, 1'b1);
        repeat (30) @(negedge clk);
        chk("R7 still locked short of timeout", locked_o, 1'b1);
        repeat (15) @(negedge clk);
        chk("R7 timeout drops lock", locked_o, 1'b0);

        // R8: enable follows drive_en_i, lock unaffected
        for (int k = 0; k < 8; k++) phase(10, 1);
        drive_en_i = 1'b0;
        settle();
        settle();
        chk("R8 oe low", locked_oe_o, 1'b0);
        chk("R8 lock unaffected", locked_o, 1'b1);
        drive_en_i = 1'b1;
        settle();
        settle();
        chk("R8 oe high", locked_oe_o, 1'b1);

        // R1: reset in lock
        rst = 1'b1;
        settle();
        settle();
        chk("R1 reset clears lock", locked_o, 1'b0);
        chk("R1 reset clears oe", locked_oe_o, 1'b0);
        rst = 1'b0;
        for (int k = 0; k < 7; k++) phase(10, 1);
        settle();
        chk("R1 run cleared by reset", locked_o, 1'b0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule